// File: doc/BRIEF.md
# UART Diagnostic Loopback Switch with Modem Status Register

This block sits between one UART channel's serial shifters and its package pins. In normal operation it passes the transmitter's serial output to the TX pin and the RX pin to the receiver. It drives the four modem output pins (DTR, RTS, OUT1, OUT2) from the modem control bits. It also synchronizes the four modem inputs (CTS, DSR, RI, CD) into the clock domain.

When the loopback control bit is set, the block isolates the pins. The transmitter's serial stream goes straight back into the receiver. The modem output controls are routed onto the internal modem-status lines in place of the external inputs. The external TX pin idles at mark, and the modem output pins are held inactive. Because the receiver, transmitter and status logic still see ordinary traffic, software can run a full diagnostic without any external wiring.

The block also keeps the modem status register. Its upper nibble is the sampled line state and its lower nibble holds sticky change flags. The flags clear on a register read, and an interrupt request is raised while any flag is set.

Top module: `uart_loop_switch`

## Requirements
- R1: `ctlBits` carries DTR in bit 0, RTS in bit 1, OUT1 in bit 2, OUT2 in bit 3 and the loopback enable in bit 4.
- R2: With loopback off, `txPin` equals `txSerial` and `rxSerial` equals `rxPin`. `dtrPin`, `rtsPin`, `out1Pin` and `out2Pin` equal `ctlBits[0..3]`. The modem lines equal the external pins delayed by SYNC_STAGES clock edges.
- R3: With loopback on, `rxSerial` equals `txSerial`, `txPin` is held at 1, and `rxPin` has no effect.
- R4: With loopback on, CTS is taken from RTS, DSR from DTR, RI from OUT1 and CD from OUT2. All four modem output pins are 0, and the external modem inputs have no effect.
- R5: `statusReg[7:4]` holds CD, RI, DSR and CTS, in that order from bit 7 down. These bits show the line values one edge after they appear on the line outputs, which is SYNC_STAGES+1 edges after an external pin changes.
- R6: Flag bits 0 (CTS), 1 (DSR) and 3 (CD) are set when the sampled line changes in either direction.
- R7: Flag bit 2 (RI) is set only when RI goes from 1 to 0. A rise of RI sets no flag.
- R8: A flag stays set until a clock edge with `statusRead` high clears all flags. A change detected at that same edge sets its flag anyway.
- R9: `modemIrq` is 1 exactly when any flag bit is set.
- R10: Entering or leaving loopback sets the flag of every non-RI line whose routed value differs from the value it replaces.
- R11: During reset `statusReg` and `modemIrq` are 0. No flag is set during the first SYNC_STAGES+1 edges after reset, while the synchronizer fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlBits | input | 5 | Modem control bits and loopback enable |
| statusRead | input | 1 | Strobe: status register read this cycle |
| txSerial | input | 1 | Serial output of the transmitter |
| rxPin | input | 1 | External receive pin |
| ctsPin | input | 1 | External CTS input |
| dsrPin | input | 1 | External DSR input |
| riPin | input | 1 | External RI input |
| cdPin | input | 1 | External CD input |
| txPin | output | 1 | External transmit pin |
| dtrPin | output | 1 | External DTR output |
| rtsPin | output | 1 | External RTS output |
| out1Pin | output | 1 | External OUT1 output |
| out2Pin | output | 1 | External OUT2 output |
| rxSerial | output | 1 | Serial input to the receiver |
| ctsLine | output | 1 | Internal CTS status |
| dsrLine | output | 1 | Internal DSR status |
| riLine | output | 1 | Internal RI status |
| cdLine | output | 1 | Internal CD status |
| statusReg | output | 8 | Modem status register: line states and change flags |
| modemIrq | output | 1 | Modem-status interrupt request |

## Verification
A stale sample register would show as a wrong upper nibble of `statusReg` one edge after a line output changes. It would also show as a missing or spurious flag at that same edge, so a defect appears at the ports within a single cycle of the stimulus. Synchronizer depth errors show as the status arriving one edge early or late after an external pin toggle. A wrong crossover mapping shows immediately on the line outputs and on the nibble the next edge. A wrong clear-versus-set priority shows as a lost flag after a read that coincides with a change.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;
  localparam int NUM_LINES = 4;
  // modem line index: also the bit order of the status register nibbles
  localparam int LINE_CTS = 0;
  localparam int LINE_DSR = 1;
  localparam int LINE_RI  = 2;
  localparam int LINE_CD  = 3;
  // control bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;
  localparam int CTL_W    = 5;

  typedef struct packed {
    logic [NUM_LINES-1:0] setMask;
    logic                 clrAll;
    logic                 warm;
  } loop_strobe_t;
endpackage

// File: rtl/uart_loop_path.sv
module uart_loop_path
  import uart_loop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CTL_W-1:0]     ctlBits,
  input  logic                 txSerial,
  input  logic                 rxPin,
  input  logic [NUM_LINES-1:0] modemPins,
  input  loop_strobe_t         strobe,
  output logic                 txPin,
  output logic                 rxSerial,
  output logic [3:0]           outPins,
  output logic [NUM_LINES-1:0] lineNow,
  output logic [NUM_LINES-1:0] lineQ,
  output logic [NUM_LINES-1:0] delta
);
  logic                        loopOn;
  logic [NUM_LINES-1:0]        loopLines;
  logic [NUM_LINES-1:0]        syncOut;
  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncQ;

  assign loopOn = ctlBits[CTL_LOOP];

  // synchronizer chain for the external modem inputs
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= modemPins;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], modemPins};
      end
    end
  endgenerate
  assign syncOut = syncQ[SYNC_STAGES-1];

  // crossover of control bits onto status lines in loopback
  always_comb begin
    loopLines           = '0;
    loopLines[LINE_CTS] = ctlBits[CTL_RTS];
    loopLines[LINE_DSR] = ctlBits[CTL_DTR];
    loopLines[LINE_RI]  = ctlBits[CTL_OUT1];
    loopLines[LINE_CD]  = ctlBits[CTL_OUT2];
  end

  assign lineNow  = loopOn ? loopLines : syncOut;
  assign txPin    = loopOn ? 1'b1 : txSerial;
  assign rxSerial = loopOn ? txSerial : rxPin;
  assign outPins  = loopOn ? 4'b0000 : ctlBits[3:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= '0;
      delta <= '0;
    end else begin
      lineQ <= lineNow;
      delta <= (delta & ~{NUM_LINES{strobe.clrAll}}) | strobe.setMask;
    end
  end

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line_chk
      if (i != LINE_RI) begin : g_edge_any
        // R6
        delta_set_chk: assert property (@(posedge clk) disable iff (!rstN)
          (!strobe.warm && (lineNow[i] != lineQ[i])) |=> delta[i]);
      end
      // R8
      delta_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (delta[i] && !strobe.clrAll) |=> delta[i]);
    end
  endgenerate

  // R7
  ri_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.warm && lineQ[LINE_RI] && !lineNow[LINE_RI]) |=> delta[LINE_RI]);
  // R7
  ri_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!delta[LINE_RI] && !(lineQ[LINE_RI] && !lineNow[LINE_RI])) |=> !delta[LINE_RI]);
  // R11
  warm_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.warm |=> (delta == '0));
endmodule

// File: rtl/uart_loop_ctrl.sv
module uart_loop_ctrl
  import uart_loop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 statusRead,
  input  logic [NUM_LINES-1:0] lineNow,
  input  logic [NUM_LINES-1:0] lineQ,
  output loop_strobe_t         strobe
);
  localparam int WARM_EDGES = SYNC_STAGES + 1;
  localparam int CNT_W      = $clog2(WARM_EDGES + 1);
  localparam logic [CNT_W-1:0] WARM_END = CNT_W'(WARM_EDGES);

  logic [CNT_W-1:0]     warmCnt;
  logic                 warmOn;
  logic [NUM_LINES-1:0] changed;
  logic                 riFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   warmCnt <= '0;
    else if (warmCnt != WARM_END) warmCnt <= warmCnt + 1'b1;
  end
  assign warmOn = (warmCnt != WARM_END);

  assign changed = lineNow ^ lineQ;
  assign riFall  = lineQ[LINE_RI] & ~lineNow[LINE_RI];

  always_comb begin
    strobe.setMask          = changed;
    strobe.setMask[LINE_RI] = riFall;
    if (warmOn) strobe.setMask = '0;
    strobe.clrAll = statusRead;
    strobe.warm   = warmOn;
  end

  // R11
  warm_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.warm |=> !strobe.warm);
endmodule

// File: rtl/uart_loop_switch.sv
module uart_loop_switch
  import uart_loop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] ctlBits,
  input  logic       statusRead,
  input  logic       txSerial,
  input  logic       rxPin,
  input  logic       ctsPin,
  input  logic       dsrPin,
  input  logic       riPin,
  input  logic       cdPin,
  output logic       txPin,
  output logic       dtrPin,
  output logic       rtsPin,
  output logic       out1Pin,
  output logic       out2Pin,
  output logic       rxSerial,
  output logic       ctsLine,
  output logic       dsrLine,
  output logic       riLine,
  output logic       cdLine,
  output logic [7:0] statusReg,
  output logic       modemIrq
);
  loop_strobe_t         strobe;
  logic [NUM_LINES-1:0] modemPins;
  logic [NUM_LINES-1:0] lineNow;
  logic [NUM_LINES-1:0] lineQ;
  logic [NUM_LINES-1:0] delta;
  logic [3:0]           outPins;

  always_comb begin
    modemPins           = '0;
    modemPins[LINE_CTS] = ctsPin;
    modemPins[LINE_DSR] = dsrPin;
    modemPins[LINE_RI]  = riPin;
    modemPins[LINE_CD]  = cdPin;
  end

  uart_loop_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .ctlBits(ctlBits), .txSerial(txSerial),
    .rxPin(rxPin), .modemPins(modemPins), .strobe(strobe),
    .txPin(txPin), .rxSerial(rxSerial), .outPins(outPins),
    .lineNow(lineNow), .lineQ(lineQ), .delta(delta)
  );

  uart_loop_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .statusRead(statusRead),
    .lineNow(lineNow), .lineQ(lineQ), .strobe(strobe)
  );

  assign dtrPin    = outPins[CTL_DTR];
  assign rtsPin    = outPins[CTL_RTS];
  assign out1Pin   = outPins[CTL_OUT1];
  assign out2Pin   = outPins[CTL_OUT2];
  assign ctsLine   = lineNow[LINE_CTS];
  assign dsrLine   = lineNow[LINE_DSR];
  assign riLine    = lineNow[LINE_RI];
  assign cdLine    = lineNow[LINE_CD];
  assign statusReg = {lineQ, delta};
  assign modemIrq  = |delta;

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modemIrq) |-> ($past(strobe.setMask) != '0));
endmodule

// File: tb/uart_loop_switch_bench.sv
module uart_loop_switch_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] ctlBits = '0;
  logic       statusRead = 1'b0;
  logic       txSerial = 1'b0, rxPin = 1'b0;
  logic       ctsPin = 1'b0, dsrPin = 1'b0, riPin = 1'b0, cdPin = 1'b0;
  logic       txPin, dtrPin, rtsPin, out1Pin, out2Pin, rxSerial;
  logic       ctsLine, dsrLine, riLine, cdLine, modemIrq;
  logic [7:0] statusReg;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  uart_loop_switch #(.SYNC_STAGES(2)) u_uart_loop_switch (
    .clk(clk), .rstN(rstN), .ctlBits(ctlBits), .statusRead(statusRead),
    .txSerial(txSerial), .rxPin(rxPin), .ctsPin(ctsPin), .dsrPin(dsrPin),
    .riPin(riPin), .cdPin(cdPin), .txPin(txPin), .dtrPin(dtrPin),
    .rtsPin(rtsPin), .out1Pin(out1Pin), .out2Pin(out2Pin),
    .rxSerial(rxSerial), .ctsLine(ctsLine), .dsrLine(dsrLine),
    .riLine(riLine), .cdLine(cdLine), .statusReg(statusReg),
    .modemIrq(modemIrq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_status();
    statusRead = 1'b1;
    tick(1);
    statusRead = 1'b0;
  endtask

  task automatic test_reset();
    ctsPin = 1'b1; cdPin = 1'b1;
    tick(2);
    check("R11 reset status", statusReg, 8'h00);
    check("R11 reset irq", {7'b0, modemIrq}, 8'h00);
    rstN = 1'b1;
    tick(5);
    // R5 R11: lines sampled, no flags from warm-up
    check("R11 warm-up no flags", statusReg, 8'h90);
    check("R11 warm-up irq", {7'b0, modemIrq}, 8'h00);
  endtask

  task automatic test_normal_paths();
    txSerial = 1'b0; rxPin = 1'b1; #1;
    check("R2 tx/rx pass", {6'b0, txPin, rxSerial}, 8'h01);
    txSerial = 1'b1; rxPin = 1'b0; #1;
    check("R2 tx/rx pass", {6'b0, txPin, rxSerial}, 8'h02);
    ctlBits = 5'b01111; #1;
    check("R1 R2 outputs", {4'b0, out2Pin, out1Pin, rtsPin, dtrPin}, 8'h0F);
    ctlBits = 5'b00101; #1;
    check("R1 R2 outputs", {4'b0, out2Pin, out1Pin, rtsPin, dtrPin}, 8'h05);
    ctlBits = 5'b00000;
    tick(1);
  endtask

  task automatic test_latency();
    dsrPin = 1'b1;
    tick(2);
    check("R2 dsr line after sync", {7'b0, dsrLine}, 8'h01);
    check("R5 status not yet", statusReg, 8'h90);
    tick(1);
    check("R5 R6 dsr rise", statusReg, 8'hB2);
    check("R9 irq set", {7'b0, modemIrq}, 8'h01);
    tick(4);
    check("R8 flag held", statusReg, 8'hB2);
    read_status();
    check("R8 read clears", statusReg, 8'hB0);
    check("R9 irq clear", {7'b0, modemIrq}, 8'h00);
  endtask

  task automatic test_ri_edges();
    riPin = 1'b1;
    tick(3);
    check("R7 ri rise no flag", statusReg, 8'hF0);
    riPin = 1'b0;
    tick(3);
    check("R7 ri fall flag", statusReg, 8'hB4);
    read_status();
    ctsPin = 1'b0;
    tick(3);
    check("R6 cts fall flag", statusReg, 8'hA1);
    read_status();
    check("R8 cleared", statusReg, 8'hA0);
  endtask

  task automatic test_loop_enter();
    ctlBits = 5'b10010;
    txSerial = 1'b0; rxPin = 1'b1; #1;
    check("R3 tx idle, rx from tx", {6'b0, txPin, rxSerial}, 8'h02);
    txSerial = 1'b1; rxPin = 1'b0; #1;
    check("R3 rx from tx", {6'b0, txPin, rxSerial}, 8'h03);
    check("R4 outputs held", {4'b0, out2Pin, out1Pin, rtsPin, dtrPin}, 8'h00);
    check("R4 crossover lines", {4'b0, cdLine, riLine, dsrLine, ctsLine}, 8'h01);
    tick(1);
    check("R10 entry flags", statusReg, 8'h1B);
    read_status();
    check("R8 cleared in loop", statusReg, 8'h10);
  endtask

  task automatic test_loop_isolation();
    ctsPin = 1'b1; dsrPin = 1'b0; cdPin = 1'b0; riPin = 1'b1;
    tick(4);
    check("R4 pins ignored", statusReg, 8'h10);
    check("R4 pins ignored irq", {7'b0, modemIrq}, 8'h00);
  endtask

  task automatic test_loop_routes();
    ctlBits = 5'b11101;
    tick(1);
    check("R4 R6 R7 routed", statusReg, 8'hEB);
    read_status();
    ctlBits = 5'b11001;
    statusRead = 1'b1;
    tick(1);
    statusRead = 1'b0;
    check("R8 set wins over clear", statusReg, 8'hA4);
    read_status();
    check("R8 cleared", statusReg, 8'hA0);
  endtask

  task automatic test_loop_exit();
    ctlBits = 5'b00000;
    txSerial = 1'b0; #1;
    check("R2 tx after exit", {7'b0, txPin}, 8'h00);
    tick(1);
    check("R10 exit flags", statusReg, 8'h5B);
    check("R9 irq on exit", {7'b0, modemIrq}, 8'h01);
  endtask

  initial begin
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_normal_paths();
    test_latency();
    test_ri_edges();
    test_loop_enter();
    test_loop_isolation();
    test_loop_routes();
    test_loop_exit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule